// File: doc/BRIEF.md
# Bang-Bang Phase Detector with Digital Loop Integrator

This block makes the phase decisions for a clock and data recovery loop. For each bit it receives three samples of the incoming data: one at the centre of the current bit (A), one near the following edge (T), and one at the centre of the next bit (B). From these it decides whether the recovered clock runs early, runs late, or has nothing to correct. It then issues a registered up or down pulse that lasts one bit period, for the proportional path of the oscillator.

The same decisions feed a saturating signed accumulator. Long runs of corrections in one direction build up in that accumulator, which serves as a frequency control word for the oscillator centre frequency. The A sample is passed out as the recovered data bit.

An external frequency window detector drives an enable input. While that enable is low, the block issues no phase corrections, the accumulator keeps its value, and a hold flag reports this state.

Top module: `bbpd_loop`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is `up_o`=0, `dn_o`=0, `data_o`=0, `hold_o`=0 and `freq_word_o`=0.
- R2: A valid sample with A equal to B produces neither an up nor a down pulse, whatever T is, and leaves `freq_word_o` unchanged.
- R3: A valid enabled sample with A equal to T and different from B (early clock) sets `dn_o` high in the cycle after the strobe.
- R4: A valid enabled sample with B equal to T and different from A (late clock) sets `up_o` high in the cycle after the strobe.
- R5: `up_o` and `dn_o` are never high together. Each pulse lasts exactly one cycle, unless the following strobe produces the same decision again.
- R6: Each up decision adds +1 to the signed two's-complement `freq_word_o`, and each down decision adds −1. Both take effect at the edge that samples the strobe.
- R7: `freq_word_o` saturates. An up decision at the maximum positive value, or a down decision at the minimum negative value, leaves it unchanged.
- R8: `data_o` takes the A sample of each valid strobe in the following cycle and keeps it while no strobe arrives. This happens whether or not the enable is high.
- R9: While `win_ok` is low, no pulse is issued and `freq_word_o` holds. `hold_o` equals the inverse of `win_ok` from the previous cycle.
- R10: With `smp_valid` low, no pulse is issued and neither `freq_word_o` nor `data_o` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Strobe: the A/T/B samples hold a new bit |
| smp_a | input | 1 | Sample at the current bit centre |
| smp_t | input | 1 | Sample near the following edge |
| smp_b | input | 1 | Sample at the next bit centre |
| win_ok | input | 1 | High when the frequency window detector reports in-window |
| up_o | output | 1 | Speed-up pulse for the proportional path |
| dn_o | output | 1 | Slow-down pulse for the proportional path |
| data_o | output | 1 | Recovered data bit |
| hold_o | output | 1 | Integrator is frozen by the window detector |
| freq_word_o | output | ACC_W | Signed frequency control word |

## Verification
The bench builds the block with `ACC_W` = 6, so the accumulator spans −32 to +31. Runs of a few dozen same-direction decisions therefore drive it into both saturation limits, which are out of reach at the default 16-bit width within the run length. All eight A/T/B combinations are applied directly. A seeded random stream then mixes strobe gaps, window drop-outs and pattern changes, and a reference model in the bench follows every cycle.

// File: rtl/bbpd_pkg.sv
// Package: shared decision encoding for the bang-bang phase detector.
// Assumes nothing beyond the user of the type including this package first.
package bbpd_pkg;
    typedef enum logic [1:0] {
        DEC_NONE  = 2'b00,
        DEC_LATE  = 2'b01,   // clock late -> speed up
        DEC_EARLY = 2'b10    // clock early -> slow down
    } bbpd_dec_e;
endpackage

// File: rtl/bbpd_decide.sv
// Module: bbpd_decide
// Combinational decision from the three samples of one bit.
// Assumes the samples are stable whenever smp_valid is high.
// Output is DEC_NONE when not valid or not enabled.
module bbpd_decide
    import bbpd_pkg::*;
(
    input  logic      smp_valid,
    input  logic      enable,
    input  logic      smp_a,
    input  logic      smp_t,
    input  logic      smp_b,
    output bbpd_dec_e dec
);
    logic edge_seen;
    assign edge_seen = smp_a ^ smp_b;

    // Classify the bit: no edge, edge seen with T matching A, or edge seen with T matching B.
    always_comb begin
        dec = DEC_NONE;
        if (smp_valid && enable && edge_seen) begin
            if (smp_t == smp_a) dec = DEC_EARLY;
            else                dec = DEC_LATE;
        end
    end
endmodule

// File: rtl/bbpd_pulse.sv
// Module: bbpd_pulse
// Registers the proportional up/down pulses, the recovered data bit and the hold flag.
// Assumes one decision per clock at most; a pulse lasts one cycle per decision.
module bbpd_pulse
    import bbpd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bbpd_dec_e dec,
    input  logic      smp_valid,
    input  logic      smp_a,
    input  logic      smp_t,
    input  logic      smp_b,
    input  logic      win_ok,
    output logic      up_o,
    output logic      dn_o,
    output logic      data_o,
    output logic      hold_o
);
    // Register the pulse pair from the current decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_o <= 1'b0;
            dn_o <= 1'b0;
        end else begin
            up_o <= (dec == DEC_LATE);
            dn_o <= (dec == DEC_EARLY);
        end
    end

    // Capture the centre sample as the recovered bit on every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         data_o <= 1'b0;
        else if (smp_valid) data_o <= smp_a;
    end

    // Report the frozen state of the integrator.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_o <= 1'b0;
        else        hold_o <= !win_ok;
    end

    assert_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_o && dn_o));
    assert_no_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (smp_a == smp_b)) |=> (!up_o && !dn_o));
    assert_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && win_ok && (smp_a == smp_t) && (smp_a != smp_b)) |=> dn_o);
    assert_late_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && win_ok && (smp_b == smp_t) && (smp_a != smp_b)) |=> up_o);
    assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !win_ok |=> (!up_o && !dn_o && hold_o));
    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> (!up_o && !dn_o && $stable(data_o)));
    assert_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (data_o == $past(smp_a)));
endmodule

// File: rtl/bbpd_integ.sv
// Module: bbpd_integ
// Saturating signed accumulator driven by the bang-bang decisions.
// Assumes at most one decision per clock; holds while the decision is DEC_NONE.
module bbpd_integ
    import bbpd_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  bbpd_dec_e               dec,
    output logic signed [ACC_W-1:0] acc_o
);
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] ONE     = {{(ACC_W-1){1'b0}}, 1'b1};

    logic at_max, at_min;
    assign at_max = (acc_o == ACC_MAX);
    assign at_min = (acc_o == ACC_MIN);

    // Step the accumulator by one per decision, clamped at both limits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else begin
            unique case (dec)
                DEC_LATE:  if (!at_max) acc_o <= acc_o + ONE;
                DEC_EARLY: if (!at_min) acc_o <= acc_o - ONE;
                default:   acc_o <= acc_o;
            endcase
        end
    end

    assert_up_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec == DEC_LATE && !at_max) |=> (acc_o == $past(acc_o) + ONE));
    assert_dn_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec == DEC_EARLY && !at_min) |=> (acc_o == $past(acc_o) - ONE));
    assert_sat_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec == DEC_LATE && at_max) |=> (acc_o == ACC_MAX));
    assert_sat_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec == DEC_EARLY && at_min) |=> (acc_o == ACC_MIN));
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec == DEC_NONE) |=> $stable(acc_o));
endmodule

// File: rtl/bbpd_loop.sv
// Module: bbpd_loop (top)
// Bang-bang phase detector: per-bit up/down pulses plus a saturating frequency integrator.
// Assumes one A/T/B sample triple per smp_valid strobe, synchronous to clk,
// and win_ok driven by an external frequency window detector.
module bbpd_loop
    import bbpd_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic                    smp_a,
    input  logic                    smp_t,
    input  logic                    smp_b,
    input  logic                    win_ok,
    output logic                    up_o,
    output logic                    dn_o,
    output logic                    data_o,
    output logic                    hold_o,
    output logic signed [ACC_W-1:0] freq_word_o
);
    bbpd_dec_e dec;

    bbpd_decide u_decide (
        .smp_valid (smp_valid),
        .enable    (win_ok),
        .smp_a     (smp_a),
        .smp_t     (smp_t),
        .smp_b     (smp_b),
        .dec       (dec)
    );

    bbpd_pulse u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec       (dec),
        .smp_valid (smp_valid),
        .smp_a     (smp_a),
        .smp_t     (smp_t),
        .smp_b     (smp_b),
        .win_ok    (win_ok),
        .up_o      (up_o),
        .dn_o      (dn_o),
        .data_o    (data_o),
        .hold_o    (hold_o)
    );

    bbpd_integ #(.ACC_W(ACC_W)) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (dec),
        .acc_o (freq_word_o)
    );

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!up_o && !dn_o && !data_o && !hold_o && freq_word_o == '0));
endmodule

// File: tb/bbpd_loop_tb.sv
module bbpd_loop_tb;
    localparam int W = 6;
    localparam int MAXV = (1 << (W-1)) - 1;
    localparam int MINV = -(1 << (W-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0, smp_a = 1'b0, smp_t = 1'b0, smp_b = 1'b0, win_ok = 1'b0;
    logic up_o, dn_o, data_o, hold_o;
    logic signed [W-1:0] freq_word_o;

    int checks = 0;
    int errors = 0;
    int e_acc = 0;
    logic e_up = 1'b0, e_dn = 1'b0, e_data = 1'b0, e_hold = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bbpd_loop #(.ACC_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_a(smp_a),
        .smp_t(smp_t), .smp_b(smp_b), .win_ok(win_ok), .up_o(up_o), .dn_o(dn_o),
        .data_o(data_o), .hold_o(hold_o), .freq_word_o(freq_word_o)
    );

    // 2'b01 = late/up, 2'b10 = early/down, 2'b00 = none
    function automatic logic [1:0] ref_dec(input logic v, input logic en,
                                           input logic a, input logic t, input logic b);
        if (!v || !en || (a == b)) return 2'b00;
        return (t == a) ? 2'b10 : 2'b01;
    endfunction

    task automatic chk(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Drive one cycle (at negedge), update model at posedge, compare at the next negedge.
    task automatic step(input logic v, input logic en, input logic a, input logic t, input logic b);
        logic [1:0] d;
        string ptag;
        string atag;
        smp_valid = v; win_ok = en; smp_a = a; smp_t = t; smp_b = b;
        d = ref_dec(v, en, a, t, b);
        @(posedge clk);
        ptag = !v ? "R10" : !en ? "R9" : (a == b) ? "R2" : (d == 2'b10) ? "R3" : "R4";
        atag = ((d == 2'b01 && e_acc == MAXV) || (d == 2'b10 && e_acc == MINV)) ? "R7" : "R6";
        e_up = d[0];
        e_dn = d[1];
        if (d == 2'b01 && e_acc < MAXV) e_acc++;
        if (d == 2'b10 && e_acc > MINV) e_acc--;
        if (v) e_data = a;
        e_hold = !en;
        @(negedge clk);
        chk(up_o, e_up, {ptag, " up"});
        chk(dn_o, e_dn, {ptag, " dn"});
        chk(int'(freq_word_o), e_acc, {atag, " acc"});
        chk(data_o, e_data, "R8 data");
        chk(hold_o, e_hold, "R9 hold");
        chk(int'(up_o & dn_o), 0, "R5 exclusive");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd24681357));
        smp_valid = 1'b1; smp_a = 1'b1; smp_t = 1'b0; smp_b = 1'b0; win_ok = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(up_o, 0, "R1 up");
        chk(dn_o, 0, "R1 dn");
        chk(data_o, 0, "R1 data");
        chk(hold_o, 0, "R1 hold");
        chk(int'(freq_word_o), 0, "R1 acc");
        rst_n = 1'b1;
        // All eight A/T/B combinations, enabled
        for (int k = 0; k < 8; k++) step(1'b1, 1'b1, k[2], k[1], k[0]);
        // R5: pulse lasts one cycle then drops on an idle cycle
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        // R9: window lost, edges present
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 1'b1, k[0], 1'b0);
        // R10: strobe low with edge patterns
        for (int k = 0; k < 4; k++) step(1'b0, 1'b1, k[0], 1'b0, !k[0]);
        // R7: run to upper limit and past it, then to lower limit and past it
        for (int k = 0; k < 2*MAXV + 6; k++) step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 4*MAXV + 10; k++) step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        // Random mix
        for (int k = 0; k < 3000; k++) begin
            logic [4:0] r;
            r = 5'($urandom);
            step($urandom_range(0, 7) != 0, $urandom_range(0, 9) != 0, r[0], r[1], r[2]);
        end
        // Mid-run reset
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(int'(freq_word_o), 0, "R1 acc after reset");
        chk(up_o | dn_o, 0, "R1 pulses after reset");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule